// File: doc/BRIEF.md
# DMA Channel Event Queue Manager

This block collects transfer triggers for a bank of DMA channels and turns them into queued transfer requests. A channel can be started in three ways: a pulse on its hardware event line, a software write that sets its bit in the event-set input, or a chain trigger raised when another transfer finishes. All three sources merge into one pending bit per channel. A channel that is triggered again while it is still pending is recorded as a missed event and does not produce a second request.

Each channel carries two programmable attributes: the index of the parameter set it uses, which is one of 512, and a 1-bit queue select that picks one of two event queues. Each cycle a fixed-priority picker chooses the lowest-numbered pending channel. If that channel's queue has room, the channel and its parameter-set index are written into the queue. Each queue is a 16-entry FIFO. It drains through its own valid/ready request port, reports its current fill level and the highest fill level seen since reset, and raises a threshold interrupt line.

Top module: `dma_evq_mgr`

## Requirements
- R1: A trigger sampled at one rising edge sets the channel pending. If the channel wins and its queue has room, the request is valid at that queue's port after the following rising edge.
- R2: An event-set write (`sw_set_we`=1) triggers every channel whose bit in `sw_set_bits` is 1. Bits that are 0 have no effect, and when `sw_set_we`=0 the bits are ignored.
- R3: Among pending channels, the lowest-numbered one is enqueued first. At most one entry is enqueued per cycle across both queues.
- R4: A trigger from any source on a channel that is already pending sets that channel's bit in `miss_err` and adds no second request. Writing a 1 to a bit of `miss_clr_bits` with `miss_clr_we`=1 clears that bit. A new miss arriving in the same cycle wins over the clear.
- R5: Each channel's parameter-set index is written with `map_we`, `map_ch` and `map_pset`. At reset it equals the channel number. A request carries the index in force when it is enqueued.
- R6: `map_q`, written together with the index, selects queue 0 when 0 and queue 1 when 1. At reset every channel selects queue 0.
- R7: A queue holds 16 entries. When the winning channel's queue is full, nothing is enqueued that cycle, the channel stays pending and is retried later, and `q_count` never exceeds 16.
- R8: `q_count` gives the number of entries held in each queue. `q_wmark` gives the largest value `q_count` has reached since reset and never decreases.
- R9: `thr_irq[q]` is high while queue q's count is at or above its threshold. The threshold is written with `thr_we`, `thr_q` and `thr_val` and resets to 16.
- R10: Entries leave a queue in the order they entered, one per cycle when valid and ready are both high. While valid is high and ready is low, the offered entry stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_CH | Hardware event pulses, one per channel |
| sw_set_we | input | 1 | Event-set write strobe |
| sw_set_bits | input | NUM_CH | Channels to trigger on an event-set write |
| chain_in | input | NUM_CH | Chain triggers from completed transfers |
| map_we | input | 1 | Channel mapping write strobe |
| map_ch | input | CH_W | Channel whose mapping is written |
| map_pset | input | PSET_W | New parameter-set index |
| map_q | input | 1 | New queue select |
| thr_we | input | 1 | Threshold write strobe |
| thr_q | input | 1 | Queue whose threshold is written |
| thr_val | input | CNT_W | New threshold |
| miss_clr_we | input | 1 | Missed-event clear strobe |
| miss_clr_bits | input | NUM_CH | Missed-event bits to clear (1 clears) |
| miss_err | output | NUM_CH | Sticky missed-event flags |
| req_valid | output | 2 | Per-queue request valid |
| req_ready | input | 2 | Per-queue request ready |
| req_ch | output | 2*CH_W | Channel at each queue head (queue q at bits q*CH_W) |
| req_pset | output | 2*PSET_W | Parameter-set index at each queue head |
| q_count | output | 2*CNT_W | Per-queue fill level |
| q_wmark | output | 2*CNT_W | Per-queue highest fill level |
| thr_irq | output | 2 | Per-queue threshold interrupt |

## Verification
A stuck or lost pending bit shows up as a request that never reaches the port, or as a second request where `miss_err` should have been set. Either appears two edges after the trigger. A wrong pick order or a stale mapping appears at the queue head as soon as that entry reaches the head. A queue count that drifts from the true fill level shows on `q_count`, and so on `q_wmark` and `thr_irq`, within one cycle. A count that drifts too high also blocks enqueues early, which leaves channels pending and changes the later order of requests.

// File: rtl/dma_evq_pkg.sv
package dma_evq_pkg;
   // number of event queues; the queue select is one bit wide
   localparam int NQ = 2;
   typedef logic qsel_t;
endpackage

// File: rtl/evq_trig.sv
module evq_trig #(
   parameter int NUM_CH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt,
   input  logic              sw_we,
   input  logic [NUM_CH-1:0] sw_bits,
   input  logic [NUM_CH-1:0] chain,
   input  logic [NUM_CH-1:0] grant_vec,
   input  logic              clr_we,
   input  logic [NUM_CH-1:0] clr_bits,
   output logic [NUM_CH-1:0] pend,
   output logic [NUM_CH-1:0] miss
);
   logic [NUM_CH-1:0] trig;
   logic [NUM_CH-1:0] clr_mask;

   always_comb begin
      trig     = evt | chain | (sw_we ? sw_bits : '0);
      clr_mask = clr_we ? clr_bits : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         miss <= '0;
      end else begin
         // a repeat trigger on a pending channel is dropped and flagged
         pend <= (pend & ~grant_vec) | (trig & ~pend);
         miss <= (miss & ~clr_mask) | (trig & pend);
      end
   end
endmodule

// File: rtl/evq_pick.sv
module evq_pick #(
   parameter int N  = 64,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/evq_fifo.sv
module evq_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 15,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [DW-1:0]    din,
   input  logic             rd_ready,
   input  logic [CNT_W-1:0] thr,
   output logic             rd_valid,
   output logic [DW-1:0]    dout,
   output logic             full,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] wmark,
   output logic             irq
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("evq_fifo: DEPTH must be at least 2");
   end

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_nx, rp_nx;
   logic             pop, do_push;
   logic [CNT_W-1:0] cnt_nx;

   assign full     = (count == CNT_W'(DEPTH));
   assign rd_valid = (count != '0);
   assign pop      = rd_valid & rd_ready;
   assign do_push  = push & ~full;
   assign dout     = mem[rp];
   assign irq      = (count >= thr);

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_nx = wp + PTR_W'(1);
      assign rp_nx = rp + PTR_W'(1);
   end else begin : g_wrap
      assign wp_nx = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + PTR_W'(1);
      assign rp_nx = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + PTR_W'(1);
   end

   always_comb cnt_nx = count + CNT_W'(do_push) - CNT_W'(pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         wmark <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (pop)     rp <= rp_nx;
         count <= cnt_nx;
         if (cnt_nx > wmark) wmark <= cnt_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end
endmodule

// File: rtl/dma_evq_mgr.sv
module dma_evq_mgr
   import dma_evq_pkg::*;
#(
   parameter int NUM_CH  = 64,
   parameter int PSET_W  = 9,
   parameter int Q_DEPTH = 16,
   parameter int CH_W    = $clog2(NUM_CH),
   parameter int CNT_W   = $clog2(Q_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CH-1:0]    evt_in,
   input  logic                 sw_set_we,
   input  logic [NUM_CH-1:0]    sw_set_bits,
   input  logic [NUM_CH-1:0]    chain_in,
   input  logic                 map_we,
   input  logic [CH_W-1:0]      map_ch,
   input  logic [PSET_W-1:0]    map_pset,
   input  logic                 map_q,
   input  logic                 thr_we,
   input  logic                 thr_q,
   input  logic [CNT_W-1:0]     thr_val,
   input  logic                 miss_clr_we,
   input  logic [NUM_CH-1:0]    miss_clr_bits,
   output logic [NUM_CH-1:0]    miss_err,
   output logic [1:0]           req_valid,
   input  logic [1:0]           req_ready,
   output logic [2*CH_W-1:0]    req_ch,
   output logic [2*PSET_W-1:0]  req_pset,
   output logic [2*CNT_W-1:0]   q_count,
   output logic [2*CNT_W-1:0]   q_wmark,
   output logic [1:0]           thr_irq
);
   localparam int ENT_W = CH_W + PSET_W;

   if (NUM_CH < 2 || CH_W != $clog2(NUM_CH)) begin : g_bad_ch
      $error("dma_evq_mgr: channel count and CH_W disagree");
   end
   if ((2 ** PSET_W) < NUM_CH) begin : g_bad_pset
      $error("dma_evq_mgr: PSET_W too narrow for default mapping");
   end
   if (CNT_W != $clog2(Q_DEPTH + 1)) begin : g_bad_cnt
      $error("dma_evq_mgr: CNT_W does not match Q_DEPTH");
   end

   logic [NUM_CH-1:0] pend, grant_vec;
   logic [PSET_W-1:0] pset_tab [NUM_CH];
   qsel_t             qsel_tab [NUM_CH];
   logic [CNT_W-1:0]  thr_reg  [NQ];
   logic              win_any, grant;
   logic [CH_W-1:0]   win_idx;
   qsel_t             win_q;
   logic [NQ-1:0]     full_q, push_q;
   logic [ENT_W-1:0]  ent_in;
   logic [ENT_W-1:0]  ent_out [NQ];

   evq_trig #(.NUM_CH(NUM_CH)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_in),
      .sw_we    (sw_set_we),
      .sw_bits  (sw_set_bits),
      .chain    (chain_in),
      .grant_vec(grant_vec),
      .clr_we   (miss_clr_we),
      .clr_bits (miss_clr_bits),
      .pend     (pend),
      .miss     (miss_err)
   );

   evq_pick #(.N(NUM_CH), .IW(CH_W)) u_pick (
      .req(pend),
      .any(win_any),
      .idx(win_idx)
   );

   always_comb begin
      win_q     = qsel_tab[win_idx];
      grant     = win_any & ~full_q[win_q];
      grant_vec = grant ? (NUM_CH'(1) << win_idx) : '0;
      ent_in    = {win_idx, pset_tab[win_idx]};
      for (int q = 0; q < NQ; q++) begin
         push_q[q] = grant & (win_q == qsel_t'(q));
      end
   end

   // channel mapping table
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) begin
            pset_tab[i] <= PSET_W'(i);
            qsel_tab[i] <= 1'b0;
         end
      end else if (map_we) begin
         pset_tab[map_ch] <= map_pset;
         qsel_tab[map_ch] <= map_q;
      end
   end

   // per-queue thresholds
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int q = 0; q < NQ; q++) thr_reg[q] <= CNT_W'(Q_DEPTH);
      end else if (thr_we) begin
         thr_reg[thr_q] <= thr_val;
      end
   end

   for (genvar q = 0; q < NQ; q++) begin : g_q
      evq_fifo #(.DEPTH(Q_DEPTH), .DW(ENT_W), .CNT_W(CNT_W)) u_fifo (
         .clk     (clk),
         .rst_n   (rst_n),
         .push    (push_q[q]),
         .din     (ent_in),
         .rd_ready(req_ready[q]),
         .thr     (thr_reg[q]),
         .rd_valid(req_valid[q]),
         .dout    (ent_out[q]),
         .full    (full_q[q]),
         .count   (q_count[q*CNT_W +: CNT_W]),
         .wmark   (q_wmark[q*CNT_W +: CNT_W]),
         .irq     (thr_irq[q])
      );
      assign req_ch[q*CH_W +: CH_W]       = ent_out[q][PSET_W +: CH_W];
      assign req_pset[q*PSET_W +: PSET_W] = ent_out[q][PSET_W-1:0];
   end
endmodule

// File: rtl/dma_evq_chk.sv
module dma_evq_chk #(
   parameter int NUM_CH = 64,
   parameter int PSET_W = 9,
   parameter int DEPTH  = 16,
   parameter int CH_W   = 6,
   parameter int CNT_W  = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          req_valid,
   input logic [1:0]          req_ready,
   input logic [2*CH_W-1:0]   req_ch,
   input logic [2*PSET_W-1:0] req_pset,
   input logic [2*CNT_W-1:0]  q_count,
   input logic [2*CNT_W-1:0]  q_wmark,
   input logic [NUM_CH-1:0]   miss_err,
   input logic                miss_clr_we,
   input logic [1:0]          push_q
);
   // R3
   one_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(push_q));

   // R4
   miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !miss_clr_we |=> ((miss_err & $past(miss_err)) == $past(miss_err)));

   for (genvar q = 0; q < 2; q++) begin : g_q
      // R7
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         int'(q_count[q*CNT_W +: CNT_W]) <= DEPTH);

      // R8
      wmark_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
         q_wmark[q*CNT_W +: CNT_W] >= q_count[q*CNT_W +: CNT_W]);

      // R8
      wmark_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> q_wmark[q*CNT_W +: CNT_W] >= $past(q_wmark[q*CNT_W +: CNT_W]));

      // R8
      count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (int'(q_count[q*CNT_W +: CNT_W]) - int'($past(q_count[q*CNT_W +: CNT_W])) <= 1) &&
                  (int'($past(q_count[q*CNT_W +: CNT_W])) - int'(q_count[q*CNT_W +: CNT_W]) <= 1));

      // R10
      hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[q] && !req_ready[q]) |=> req_valid[q] &&
            $stable(req_ch[q*CH_W +: CH_W]) && $stable(req_pset[q*PSET_W +: PSET_W]));
   end
endmodule

bind dma_evq_mgr dma_evq_chk #(
   .NUM_CH(NUM_CH), .PSET_W(PSET_W), .DEPTH(Q_DEPTH), .CH_W(CH_W), .CNT_W(CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_ch     (req_ch),
   .req_pset   (req_pset),
   .q_count    (q_count),
   .q_wmark    (q_wmark),
   .miss_err   (miss_err),
   .miss_clr_we(miss_clr_we),
   .push_q     (push_q)
);

// File: tb/dma_evq_mgr_test.sv
module dma_evq_mgr_test;
   localparam int NCH = 64, PW = 9, DEP = 16, CW = 6, NW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NCH-1:0] evt_in = '0, sw_set_bits = '0, chain_in = '0, miss_clr_bits = '0;
   logic sw_set_we = 0, map_we = 0, map_q = 0, thr_we = 0, thr_q = 0, miss_clr_we = 0;
   logic [CW-1:0] map_ch = '0;
   logic [PW-1:0] map_pset = '0;
   logic [NW-1:0] thr_val = '0;
   logic [1:0] req_ready = '0;
   logic [NCH-1:0] miss_err;
   logic [1:0] req_valid, thr_irq;
   logic [2*CW-1:0] req_ch;
   logic [2*PW-1:0] req_pset;
   logic [2*NW-1:0] q_count, q_wmark;

   int checks = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   dma_evq_mgr uut (.*);

   // reference model state
   logic [NCH-1:0] m_pend, m_miss;
   int m_pset [NCH];
   int m_qsel [NCH];
   int m_thr [2], m_cnt [2], m_wm [2], m_hd [2], m_tl [2];
   int m_qch [2][DEP];
   int m_qps [2][DEP];

   task automatic model_reset();
      m_pend = '0; m_miss = '0;
      for (int i = 0; i < NCH; i++) begin m_pset[i] = i; m_qsel[i] = 0; end
      for (int q = 0; q < 2; q++) begin
         m_thr[q] = DEP; m_cnt[q] = 0; m_wm[q] = 0; m_hd[q] = 0; m_tl[q] = 0;
      end
   endtask

   task automatic model_step();
      logic [NCH-1:0] trig, gvec, old_pend;
      int w, wq;
      bit g;
      trig = evt_in | chain_in | (sw_set_we ? sw_set_bits : '0);
      old_pend = m_pend;
      w = -1;
      for (int i = NCH - 1; i >= 0; i--) if (m_pend[i]) w = i;
      g = 0; wq = 0; gvec = '0;
      if (w >= 0) begin
         wq = m_qsel[w];
         if (m_cnt[wq] < DEP) begin g = 1; gvec[w] = 1'b1; end
      end
      for (int q = 0; q < 2; q++)
         if (m_cnt[q] > 0 && req_ready[q]) begin m_hd[q] = (m_hd[q] + 1) % DEP; m_cnt[q]--; end
      if (g) begin
         m_qch[wq][m_tl[wq]] = w;
         m_qps[wq][m_tl[wq]] = m_pset[w];
         m_tl[wq] = (m_tl[wq] + 1) % DEP;
         m_cnt[wq]++;
      end
      if (miss_clr_we) m_miss = m_miss & ~miss_clr_bits;
      m_miss = m_miss | (trig & old_pend);
      m_pend = (old_pend & ~gvec) | (trig & ~old_pend);
      if (map_we) begin m_pset[map_ch] = map_pset; m_qsel[map_ch] = map_q; end
      if (thr_we) m_thr[thr_q] = thr_val;
      for (int q = 0; q < 2; q++) if (m_cnt[q] > m_wm[q]) m_wm[q] = m_cnt[q];
   endtask

   initial model_reset();
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else model_step();
   end

   task automatic chk(string tag, longint got, longint exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // compare every port against the model
   task automatic compare_all();
      for (int q = 0; q < 2; q++) begin
         chk(q == 0 ? "R1 R7 queue0 valid" : "R6 queue1 valid", req_valid[q], m_cnt[q] > 0);
         if (m_cnt[q] > 0) begin
            chk("R2 R3 R10 head channel", req_ch[q*CW +: CW], m_qch[q][m_hd[q]]);
            chk("R5 head parameter set", req_pset[q*PW +: PW], m_qps[q][m_hd[q]]);
         end
         chk("R8 count", q_count[q*NW +: NW], m_cnt[q]);
         chk("R8 watermark", q_wmark[q*NW +: NW], m_wm[q]);
         chk("R9 threshold irq", thr_irq[q], m_cnt[q] >= m_thr[q]);
      end
      chk("R4 missed events", miss_err, m_miss);
   endtask

   task automatic quiet();
      evt_in = '0; chain_in = '0; sw_set_we = 0; sw_set_bits = '0;
      map_we = 0; thr_we = 0; miss_clr_we = 0; miss_clr_bits = '0;
   endtask

   task automatic tick();
      @(negedge clk);
      compare_all();
      quiet();
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk("R9 reset irq low", thr_irq, 0);
      chk("R8 reset count", q_count, 0);

      // R2 R3: event-set and hardware event together; order 3,5,40
      req_ready = 2'b00;
      sw_set_we = 1; sw_set_bits = (64'd1 << 5) | (64'd1 << 3); evt_in = 64'd1 << 40;
      tick();
      sw_set_bits = 64'hFFFF_FFFF_FFFF_FFFF;   // ignored: strobe low (R2)
      tick(); tick(); tick(); tick();
      chk("R3 first is channel 3", req_ch[CW-1:0], 3);
      chk("R2 only three entries", q_count[NW-1:0], 3);
      req_ready = 2'b01;
      tick(); chk("R3 second is channel 5", req_ch[CW-1:0], 5);
      tick(); chk("R3 third is channel 40", req_ch[CW-1:0], 40);
      tick(); tick();

      // R7 R4 R9: fill queue 0 and leave channels pending
      req_ready = 2'b00;
      sw_set_we = 1; sw_set_bits = 64'hF_FFFF;
      tick();
      repeat (20) tick();
      chk("R7 queue full at 16", q_count[NW-1:0], 16);
      chk("R9 irq at default threshold", thr_irq[0], 1);
      chain_in = 64'd1 << 18;
      tick();
      tick();
      chk("R4 miss bit 18 set", miss_err[18], 1);
      req_ready = 2'b01;
      repeat (30) tick();
      chk("R4 no duplicate for 18", q_count[NW-1:0], 0);
      miss_clr_we = 1; miss_clr_bits = 64'd1 << 18;
      tick(); tick();
      chk("R4 miss cleared", miss_err[18], 0);

      // R5 R6: channel 9 to queue 1, set 300
      map_we = 1; map_ch = 6'd9; map_pset = 9'd300; map_q = 1;
      tick();
      evt_in = 64'd1 << 9; req_ready = 2'b00;
      tick(); tick(); tick();
      chk("R6 queue1 has entry", req_valid[1], 1);
      chk("R5 mapped set 300", req_pset[PW +: PW], 300);
      thr_we = 1; thr_q = 1; thr_val = 5'd1;
      tick(); tick();
      chk("R9 programmed threshold", thr_irq[1], 1);
      req_ready = 2'b11;
      tick(); tick();

      // random phase
      for (int n = 0; n < 4000; n++) begin
         if ($urandom % 6 == 0) evt_in = 64'd1 << ($urandom % NCH);
         if ($urandom % 8 == 0) chain_in = 64'd1 << ($urandom % NCH);
         if ($urandom % 10 == 0) begin
            sw_set_we = 1;
            sw_set_bits = (64'd1 << ($urandom % NCH)) | (64'd1 << ($urandom % NCH));
         end else if ($urandom % 10 == 0) begin
            sw_set_bits = {$urandom, $urandom};   // strobe low: ignored (R2)
         end
         if ($urandom % 16 == 0) begin
            map_we = 1; map_ch = CW'($urandom); map_pset = PW'($urandom); map_q = 1'($urandom);
         end
         if ($urandom % 40 == 0) begin
            thr_we = 1; thr_q = 1'($urandom); thr_val = NW'($urandom % 17);
         end
         if ($urandom % 32 == 0) begin
            miss_clr_we = 1; miss_clr_bits = {$urandom, $urandom};
         end
         req_ready[0] = ($urandom % 4) != 0;
         req_ready[1] = ($urandom % 3) != 0;
         if ((n / 500) % 2 == 1) req_ready = req_ready & 2'(($urandom % 8 == 0) ? 3 : 0);
         tick();
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule